// File: doc/BRIEF.md
# Thermal Stop-Clock Throttle Generator

This block slows a processor under thermal stress by producing a periodic stop-clock waveform. A free-running throttle counter walks through a period of 16 counts. The stop-clock output is high for the first N counts of each period, where N is a 4-bit duty value. Throttling begins when thermal throttling is enabled and a synchronized thermal event is seen. It also begins whenever a synchronized thermal override is seen, whatever the enable says. Once throttling is running, the throttle condition is sampled only at the end of each period.

A wake or break event interrupts throttling at once. The counter freezes at its current value. Throttling resumes only after both event inputs have stayed low for one full period and the throttle condition still holds. A resume-policy input selects where the counter restarts: from zero (the default count) or from the count it held when it was interrupted.

The enable and resume-policy inputs are driven by a control register elsewhere. That register resets both bits to zero. All pins are plain control signals, and there is no streaming interface.

Top module: `thermal_throttle_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `stpclk_o` is 0 and the block is idle.
- R2: With `therm_en_i`=1, a thermal event starts throttling. `stpclk_o` is then 1 on counts 0..N-1 of each 16-count period and 0 on counts N..15, where N = `duty_i`.
- R3: With `therm_en_i`=0, a thermal event has no effect on `stpclk_o`. An asserted `therm_ovr_i` starts throttling regardless of the enable.
- R4: While throttling, the condition (enable AND thermal event, OR override) is sampled only at count 15. If it is false there, the block goes idle and `stpclk_o` stays 0.
- R5: A cycle with `wake_i` or `brk_i` high forces `stpclk_o` to 0 from the next cycle on. The throttle count stays frozen while interrupted.
- R6: Throttling resumes at the edge that ends the 16th consecutive cycle with both `wake_i` and `brk_i` low, provided the condition still holds there. Any event in that window restarts the window. If the condition is false at that edge, the block goes idle.
- R7: On resumption, `cnt_reload_i`=1 restarts the count at 0. `cnt_reload_i`=0 continues from the frozen count.
- R8: With `duty_i`=0, `stpclk_o` is never 1.
- R9: `therm_evt_i` and `therm_ovr_i` pass through two synchronizer flops. Starting from idle, an input raised before edge 1 gives `stpclk_o`=1 (if N>0) only after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_en_i | input | 1 | Thermal throttle enable |
| cnt_reload_i | input | 1 | Resume policy: 1 restart from 0, 0 continue |
| duty_i | input | 4 | Stop-clock counts per 16-count period |
| therm_evt_i | input | 1 | Asynchronous thermal event |
| therm_ovr_i | input | 1 | Asynchronous thermal override |
| wake_i | input | 1 | Wake event, synchronous |
| brk_i | input | 1 | Break event, synchronous |
| stpclk_o | output | 1 | Stop-clock request, active high |

## Verification
The hardest state to reach from the ports is a resumption that lands mid-duty from a frozen count. That requires an event at a chosen count, a quiet window of exactly 16 cycles with the condition still true, and a duty value that splits the saved count from zero. Directed sequences place a single wake pulse at count 10 with N=8, then resume under each policy. Under one policy the output stays low; under the other it returns high. Further sequences re-pulse break inside the quiet window and drop the condition just before the window ends. A seeded random phase mixes enable, override, duty and sparse wake and break pulses against a cycle-level reference model.

// File: rtl/thr_pkg.sv
`timescale 1ns/1ps
package thr_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_RUN  = 2'd1,
    TS_HOLD = 2'd2
  } thr_state_e;
endpackage

// File: rtl/thr_sync.sv
`timescale 1ns/1ps
module thr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/thr_ctrl.sv
`timescale 1ns/1ps
module thr_ctrl
  import thr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond_i,
  input  logic             evt_i,
  input  logic             reload_i,
  output thr_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] quiet_o
);
  localparam logic [CNT_W-1:0] LAST = '1;

  thr_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TS_IDLE;
      cnt_q   <= '0;
      quiet_q <= '0;
    end else begin
      unique case (st_q)
        TS_IDLE: begin
          if (cond_i && !evt_i) begin
            st_q  <= TS_RUN;
            cnt_q <= '0;
          end
        end
        TS_RUN: begin
          if (evt_i) begin
            st_q    <= TS_HOLD;
            quiet_q <= '0;
          end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            if (!cond_i) st_q <= TS_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        TS_HOLD: begin
          if (evt_i) begin
            quiet_q <= '0;
          end else if (quiet_q == LAST) begin
            if (cond_i) begin
              st_q <= TS_RUN;
              if (reload_i) cnt_q <= '0;
            end else begin
              st_q  <= TS_IDLE;
              cnt_q <= '0;
            end
          end else begin
            quiet_q <= quiet_q + 1'b1;
          end
        end
        default: st_q <= TS_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
  assign quiet_o = quiet_q;
endmodule

// File: rtl/thr_duty_cmp.sv
`timescale 1ns/1ps
module thr_duty_cmp #(
  parameter int CNT_W = 4
) (
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             stpclk_o
);
  always_comb stpclk_o = active_i && (cnt_i < duty_i);
endmodule

// File: rtl/thermal_throttle_gen.sv
`timescale 1ns/1ps
module thermal_throttle_gen
  import thr_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             therm_en_i,
  input  logic             cnt_reload_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             therm_evt_i,
  input  logic             therm_ovr_i,
  input  logic             wake_i,
  input  logic             brk_i,
  output logic             stpclk_o
);
  logic [1:0]       sync_q;
  logic             cond;
  logic             evt;
  thr_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] quiet;

  thr_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({therm_ovr_i, therm_evt_i}),
    .q_o   (sync_q)
  );

  assign cond = (therm_en_i && sync_q[0]) || sync_q[1];
  assign evt  = wake_i || brk_i;

  thr_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond_i   (cond),
    .evt_i    (evt),
    .reload_i (cnt_reload_i),
    .state_o  (state),
    .cnt_o    (cnt),
    .quiet_o  (quiet)
  );

  thr_duty_cmp #(.CNT_W(CNT_W)) cmp_i (
    .active_i (state == TS_RUN),
    .cnt_i    (cnt),
    .duty_i   (duty_i),
    .stpclk_o (stpclk_o)
  );
endmodule

// File: rtl/thr_checker.sv
`timescale 1ns/1ps
module thr_checker
  import thr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wake_i,
  input logic             brk_i,
  input logic             cnt_reload_i,
  input logic [CNT_W-1:0] duty_i,
  input logic             stpclk_o,
  input logic             cond,
  input thr_state_e       state,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] quiet
);
  localparam logic [CNT_W-1:0] LAST = '1;
  logic ev;
  logic resume_now;
  assign ev         = wake_i || brk_i;
  assign resume_now = (state == TS_HOLD) && (quiet == LAST) && !ev && cond;

  a_r5_evt_drops_stpclk: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> !stpclk_o);

  a_r8_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0) |-> !stpclk_o);

  a_r5_hold_freezes_count: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TS_HOLD) && !((quiet == LAST) && !ev)) |=> ((state == TS_HOLD) && $stable(cnt)));

  a_r7_reload_on_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_now && cnt_reload_i) |=> ((state == TS_RUN) && (cnt == '0)));

  a_r7_continue_on_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_now && !cnt_reload_i) |=> ((state == TS_RUN) && $stable(cnt)));

  a_r4_run_steps: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TS_RUN) && !ev) |=> (cnt == $past(cnt) + 1'b1));

  a_r3_idle_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TS_IDLE) && !cond) |=> (state == TS_IDLE));
endmodule

bind thermal_throttle_gen thr_checker #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wake_i       (wake_i),
  .brk_i        (brk_i),
  .cnt_reload_i (cnt_reload_i),
  .duty_i       (duty_i),
  .stpclk_o     (stpclk_o),
  .cond         (cond),
  .state        (state),
  .cnt          (cnt),
  .quiet        (quiet)
);

// File: tb/thermal_throttle_gen_tb.sv
`timescale 1ns/1ps
module thermal_throttle_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       therm_en_i = 1'b0, cnt_reload_i = 1'b0;
  logic [3:0] duty_i = 4'd0;
  logic       therm_evt_i = 1'b0, therm_ovr_i = 1'b0, wake_i = 1'b0, brk_i = 1'b0;
  logic       stpclk_o;

  int    n_chk = 0, n_fail = 0;
  string cur_tag = "";
  bit    finished = 1'b0;

  // reference model state: 0 idle, 1 running, 2 interrupted
  int    m_mode = 0, m_pos = 0, m_quiet = 0;
  bit    m_t1 = 0, m_t2 = 0, m_o1 = 0, m_o2 = 0;

  always #4 clk = ~clk;

  thermal_throttle_gen dut_i (
    .clk(clk), .rst_n(rst_n), .therm_en_i(therm_en_i), .cnt_reload_i(cnt_reload_i),
    .duty_i(duty_i), .therm_evt_i(therm_evt_i), .therm_ovr_i(therm_ovr_i),
    .wake_i(wake_i), .brk_i(brk_i), .stpclk_o(stpclk_o)
  );

  function automatic bit exp_stpclk();
    return (m_mode == 1) && (m_pos < int'(duty_i));
  endfunction

  task automatic model_edge();
    bit go, ev;
    if (!rst_n) begin
      m_mode = 0; m_pos = 0; m_quiet = 0;
      m_t1 = 0; m_t2 = 0; m_o1 = 0; m_o2 = 0;
      return;
    end
    go = (therm_en_i && m_t2) || m_o2;
    ev = wake_i || brk_i;
    if (m_mode == 0) begin
      if (go && !ev) begin m_mode = 1; m_pos = 0; end
    end else if (m_mode == 1) begin
      if (ev) begin m_mode = 2; m_quiet = 0; end
      else if (m_pos == 15) begin m_pos = 0; if (!go) m_mode = 0; end
      else m_pos++;
    end else begin
      if (ev) m_quiet = 0;
      else if (m_quiet < 15) m_quiet++;
      else if (go) begin m_mode = 1; if (cnt_reload_i) m_pos = 0; end
      else begin m_mode = 0; m_pos = 0; end
    end
    m_t2 = m_t1; m_t1 = therm_evt_i;
    m_o2 = m_o1; m_o1 = therm_ovr_i;
  endtask

  task automatic check_out();
    bit    e;
    string tag;
    e = exp_stpclk();
    if (cur_tag != "") tag = cur_tag;
    else if (duty_i == 4'd0) tag = "R8";
    else if (m_mode == 2) tag = "R5";
    else tag = "R2";
    n_chk++;
    if (stpclk_o !== e) begin
      n_fail++;
      $display("FAIL %s stpclk_o actual=%0b expected=%0b t=%0t", tag, stpclk_o, e, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_out();
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    // R1: reset state
    cur_tag = "R1";
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R9: synchronizer latency, expect 0,0,1
    cur_tag = "R9";
    therm_en_i = 1; duty_i = 4'd4; therm_evt_i = 1;
    tick(3);
    // R2: duty shape over several periods
    cur_tag = "R2";
    tick(40);
    duty_i = 4'd15; tick(32);
    duty_i = 4'd1;  tick(32);
    // R3: enable clear ignores thermal event, override alone throttles
    cur_tag = "R3";
    therm_en_i = 0; duty_i = 4'd6; tick(40);
    therm_ovr_i = 1; tick(40);
    // R4: drop condition mid-period, must finish the period then stop
    cur_tag = "R4";
    tick(5); therm_ovr_i = 0; tick(40);
    // R8: zero duty with condition held
    cur_tag = "R8";
    therm_en_i = 1; duty_i = 4'd0; tick(40);
    // R7: freeze at count 10 with N=8, resume under each policy
    cur_tag = "R7";
    therm_en_i = 1; therm_evt_i = 1;
    for (int pol = 0; pol < 2; pol++) begin
      cnt_reload_i = pol[0]; duty_i = 4'd8;
      while (!(m_mode == 1 && m_pos == 10)) tick(1);
      wake_i = 1; tick(1); wake_i = 0;
      tick(24);
    end
    // R6: re-pulse break inside quiet window, then drop condition before resume
    cur_tag = "R6";
    duty_i = 4'd10; tick(20);
    brk_i = 1; tick(1); brk_i = 0; tick(10);
    brk_i = 1; tick(1); brk_i = 0; tick(14);
    therm_evt_i = 0; tick(30);
    therm_evt_i = 1; tick(30);
    // R5: event held several cycles
    cur_tag = "R5";
    wake_i = 1; tick(5); wake_i = 0; tick(20);
    // random phase
    cur_tag = "";
    for (int seg = 0; seg < 250; seg++) begin
      int len;
      therm_en_i   = $urandom_range(0, 3) != 0;
      cnt_reload_i = $urandom_range(0, 1);
      duty_i       = 4'($urandom_range(0, 15));
      therm_evt_i  = $urandom_range(0, 2) != 0;
      therm_ovr_i  = $urandom_range(0, 4) == 0;
      len = $urandom_range(10, 80);
      for (int c = 0; c < len; c++) begin
        wake_i = $urandom_range(0, 39) == 0;
        brk_i  = $urandom_range(0, 39) == 0;
        tick(1);
      end
      wake_i = 0; brk_i = 0;
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule